// File: doc/BRIEF.md
# Floating-Point Conditional Branch Unit

This block resolves a conditional branch that depends on the floating-point status flags. When a branch is issued it picks one of twenty-one conditions with a 5-bit selector, tests that condition against the flags, and produces the next program counter. It also produces a request to save the return address and the status register. Three displacement sources are supported: a 15-bit sign-extended short field, a full 32-bit field, and a value taken from an address register. All address arithmetic wraps modulo 2^32.

The condition logic takes NaN into account. Ordered comparisons are false when the operands were unordered, and their negated forms are true in that case. Conditions that do not allow for NaN (the ordered comparisons, their negations, and the infinity tests) raise a pair of exception-flag set pulses when the NaN flag is present. The next PC, the push request and the flag pulses are all registered on one clock edge, so the surrounding pipeline sees every effect of a branch in the same cycle.

`pc_cur` is the address of the branch itself. The sequential address is `pc_cur + 1`, and it also serves as the return address and the base for the displacement.

Top module: `fpbr_unit`

## Requirements
- R1: A synchronous active-high reset clears `pc_next` to zero and deasserts `push_req`, `siop_set` and `uncc_set`.
- R2: When an issued branch's condition is false, `pc_next` becomes `pc_cur + 1` on the next edge and `push_req` stays low.
- R3: When an issued branch's condition is true, on the next edge `push_req` is high for one cycle with `push_ret = pc_cur + 1` and `push_sr = sr_cur`, and `pc_next = pc_cur + 1 + displacement`.
- R4: With `disp_mode` = 0 the displacement is `disp_short` sign-extended from bit 14.
- R5: With `disp_mode` = 1 the displacement is `disp_long`. With `disp_mode` = 2 or 3 it is `reg_val`.
- R6: Selector codes and equations: 0 EQ (Z), 1 NE (~Z), 2 MI (N), 3 PL (~N), 4 OR (~NAN), 5 UN (NAN), 7 GLE (~NAN), 8 NGLE (NAN), 19 INF (I), 20 NINF (~I).
- R7: Ordered comparisons: 9 GE = ~(NAN|(N&~Z)), 11 GL = ~(NAN|Z), 13 GT = ~(NAN|Z|N), 15 LE = ~(NAN|~(N|Z)), 17 LT = ~(NAN|Z|~N). Codes 10, 12, 14, 16 and 18 are their complements (NGE, NGL, NGT, NLE, NLT).
- R8: Code 6 (ERR) is true when any of UNCC, SNAN, OPERR, OVF, UNF or DZ is set.
- R9: An issued branch with a code in 7..20 while NAN is set drives `siop_set` and `uncc_set` high together for exactly one cycle. Codes 0..6 never drive them.
- R10: Codes 21..31 are never true and never drive the flag pulses.
- R11: While `br_valid` is low, `pc_next` holds, and `push_req`, `siop_set` and `uncc_set` are low.
- R12: All PC arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_valid | input | 1 | A branch is issued this cycle |
| pc_cur | input | 32 | Address of the branch |
| cond_sel | input | 5 | Condition selector |
| disp_mode | input | 2 | 0 short, 1 long, 2/3 register |
| disp_short | input | 15 | Short displacement |
| disp_long | input | 32 | Long displacement |
| reg_val | input | 32 | Address-register displacement |
| sr_cur | input | 16 | Status register to save |
| fz | input | 1 | Zero flag |
| fn | input | 1 | Negative flag |
| finf | input | 1 | Infinity flag |
| fnan | input | 1 | NaN flag |
| funcc | input | 1 | Unordered-condition error flag |
| fsnan | input | 1 | Signalling NaN flag |
| foperr | input | 1 | Operand error flag |
| fovf | input | 1 | Overflow flag |
| funf | input | 1 | Underflow flag |
| fdz | input | 1 | Divide-by-zero flag |
| pc_next | output | 32 | Registered next program counter |
| push_req | output | 1 | Save return address and status |
| push_ret | output | 32 | Return address to save |
| push_sr | output | 16 | Status register to save |
| siop_set | output | 1 | Set pulse for the invalid-operation enable flag |
| uncc_set | output | 1 | Set pulse for the unordered-condition error bit |

## Verification
A taken branch and the NaN exception pulse can fall in the same cycle. This happens when a negated ordered comparison such as NGE or NGT is issued with NAN set: the condition is true and the hazard is present at once. The bench issues such branches and checks the push request, return address, target PC and both flag pulses together in a single scoreboard item. It also issues the non-negated forms under NaN, where the pulses must appear with no push and a sequential PC.

// File: rtl/fpbr_pkg.sv
package fpbr_pkg;

    localparam int PC_W    = 32;
    localparam int SHORT_W = 15;
    localparam int SR_W    = 16;
    localparam int SEL_W   = 5;
    localparam int LAST_CODE = 20;

    typedef enum logic [SEL_W-1:0] {
        C_EQ   = 5'd0,
        C_NE   = 5'd1,
        C_MI   = 5'd2,
        C_PL   = 5'd3,
        C_OR   = 5'd4,
        C_UN   = 5'd5,
        C_ERR  = 5'd6,
        C_GLE  = 5'd7,
        C_NGLE = 5'd8,
        C_GE   = 5'd9,
        C_NGE  = 5'd10,
        C_GL   = 5'd11,
        C_NGL  = 5'd12,
        C_GT   = 5'd13,
        C_NGT  = 5'd14,
        C_LE   = 5'd15,
        C_NLE  = 5'd16,
        C_LT   = 5'd17,
        C_NLT  = 5'd18,
        C_INF  = 5'd19,
        C_NINF = 5'd20
    } cond_e;

    typedef enum logic [1:0] {
        M_SHORT = 2'd0,
        M_LONG  = 2'd1,
        M_REG   = 2'd2,
        M_REG2  = 2'd3
    } mode_e;

    typedef struct packed {
        logic z;
        logic n;
        logic inf;
        logic nan;
        logic uncc;
        logic snan;
        logic operr;
        logic ovf;
        logic unf;
        logic dz;
    } fpflags_t;

    typedef struct packed {
        logic hit;
        logic non_aware;
    } verdict_t;

    function automatic logic err_any(fpflags_t f);
        return f.uncc | f.snan | f.operr | f.ovf | f.unf | f.dz;
    endfunction

    // Positive (non-negated) form of each ordered comparison pair
    function automatic logic ordered_base(logic [SEL_W-1:0] sel, fpflags_t f);
        logic r;
        case (sel)
            C_GE, C_NGE: r = ~(f.nan | (f.n & ~f.z));
            C_GL, C_NGL: r = ~(f.nan | f.z);
            C_GT, C_NGT: r = ~(f.nan | f.z | f.n);
            C_LE, C_NLE: r = ~(f.nan | ~(f.n | f.z));
            C_LT, C_NLT: r = ~(f.nan | f.z | ~f.n);
            default:     r = 1'b0;
        endcase
        return r;
    endfunction

    function automatic logic is_negated_ordered(logic [SEL_W-1:0] sel);
        return (sel == C_NGE) || (sel == C_NGL) || (sel == C_NGT) ||
               (sel == C_NLE) || (sel == C_NLT);
    endfunction

    function automatic logic [PC_W-1:0] sext_short(logic [SHORT_W-1:0] s);
        return {{(PC_W-SHORT_W){s[SHORT_W-1]}}, s};
    endfunction

endpackage

// File: rtl/fpbr_cond_eval.sv
module fpbr_cond_eval
    import fpbr_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    input  fpflags_t         flags,
    output verdict_t         verdict
);

    logic simple_hit;
    logic simple_known;
    logic ord_hit;
    logic ord_known;
    logic aware_code;

    // Conditions with a direct single-flag test
    always_comb begin
        simple_known = 1'b1;
        case (sel)
            C_EQ:    simple_hit = flags.z;
            C_NE:    simple_hit = ~flags.z;
            C_MI:    simple_hit = flags.n;
            C_PL:    simple_hit = ~flags.n;
            C_OR:    simple_hit = ~flags.nan;
            C_UN:    simple_hit = flags.nan;
            C_ERR:   simple_hit = err_any(flags);
            C_GLE:   simple_hit = ~flags.nan;
            C_NGLE:  simple_hit = flags.nan;
            C_INF:   simple_hit = flags.inf;
            C_NINF:  simple_hit = ~flags.inf;
            default: begin
                simple_hit   = 1'b0;
                simple_known = 1'b0;
            end
        endcase
    end

    // Ordered comparison pairs share one evaluator, negation applied after
    always_comb begin
        ord_known = (sel >= C_GE) && (sel <= C_NLT);
        ord_hit   = ordered_base(sel, flags) ^ is_negated_ordered(sel);
        if (!ord_known) ord_hit = 1'b0;
    end

    assign aware_code = (sel <= C_ERR);

    always_comb begin
        verdict.hit       = (simple_known & simple_hit) | (ord_known & ord_hit);
        verdict.non_aware = (simple_known | ord_known) & ~aware_code;
    end

endmodule

// File: rtl/fpbr_disp_sel.sv
module fpbr_disp_sel
    import fpbr_pkg::*;
#(
    parameter int AW = PC_W,
    parameter int SW = SHORT_W
) (
    input  logic [1:0]    mode,
    input  logic [SW-1:0] d_short,
    input  logic [AW-1:0] d_long,
    input  logic [AW-1:0] d_reg,
    output logic [AW-1:0] disp
);

    logic [AW-1:0] short_ext;

    generate
        if (SW < AW) begin : g_ext
            assign short_ext = {{(AW-SW){d_short[SW-1]}}, d_short};
        end else begin : g_trunc
            assign short_ext = d_short[AW-1:0];
        end
    endgenerate

    always_comb begin
        case (mode)
            M_SHORT: disp = short_ext;
            M_LONG:  disp = d_long;
            default: disp = d_reg;
        endcase
    end

endmodule

// File: rtl/fpbr_target.sv
module fpbr_target #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] pc_here,
    input  logic [AW-1:0] disp,
    output logic [AW-1:0] seq_pc,
    output logic [AW-1:0] tgt_pc
);

    assign seq_pc = pc_here + AW'(1);
    assign tgt_pc = seq_pc + disp;

endmodule

// File: rtl/fpbr_unit.sv
module fpbr_unit
    import fpbr_pkg::*;
#(
    parameter int AW  = PC_W,
    parameter int SW  = SHORT_W,
    parameter int SRW = SR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             br_valid,
    input  logic [AW-1:0]    pc_cur,
    input  logic [SEL_W-1:0] cond_sel,
    input  logic [1:0]       disp_mode,
    input  logic [SW-1:0]    disp_short,
    input  logic [AW-1:0]    disp_long,
    input  logic [AW-1:0]    reg_val,
    input  logic [SRW-1:0]   sr_cur,
    input  logic             fz,
    input  logic             fn,
    input  logic             finf,
    input  logic             fnan,
    input  logic             funcc,
    input  logic             fsnan,
    input  logic             foperr,
    input  logic             fovf,
    input  logic             funf,
    input  logic             fdz,
    output logic [AW-1:0]    pc_next,
    output logic             push_req,
    output logic [AW-1:0]    push_ret,
    output logic [SRW-1:0]   push_sr,
    output logic             siop_set,
    output logic             uncc_set
);

    fpflags_t      flags;
    verdict_t      verdict;
    logic [AW-1:0] disp;
    logic [AW-1:0] seq_pc;
    logic [AW-1:0] tgt_pc;
    logic          taken;
    logic          hazard;

    assign flags = '{z: fz, n: fn, inf: finf, nan: fnan, uncc: funcc,
                     snan: fsnan, operr: foperr, ovf: fovf, unf: funf, dz: fdz};

    fpbr_cond_eval u_cond (
        .sel     (cond_sel),
        .flags   (flags),
        .verdict (verdict)
    );

    fpbr_disp_sel #(.AW(AW), .SW(SW)) u_disp (
        .mode    (disp_mode),
        .d_short (disp_short),
        .d_long  (disp_long),
        .d_reg   (reg_val),
        .disp    (disp)
    );

    fpbr_target #(.AW(AW)) u_tgt (
        .pc_here (pc_cur),
        .disp    (disp),
        .seq_pc  (seq_pc),
        .tgt_pc  (tgt_pc)
    );

    assign taken  = br_valid & verdict.hit;
    assign hazard = br_valid & verdict.non_aware & fnan;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_next  <= '0;
            push_req <= 1'b0;
            push_ret <= '0;
            push_sr  <= '0;
            siop_set <= 1'b0;
            uncc_set <= 1'b0;
        end else begin
            push_req <= taken;
            siop_set <= hazard;
            uncc_set <= hazard;
            if (br_valid) begin
                pc_next <= taken ? tgt_pc : seq_pc;
            end
            if (taken) begin
                push_ret <= seq_pc;
                push_sr  <= sr_cur;
            end
        end
    end

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !br_valid |=> ($stable(pc_next) && !push_req && !siop_set && !uncc_set));

    // R3
    push_ret_chk: assert property (@(posedge clk) disable iff (rst)
        br_valid |=> (!push_req || (push_ret == $past(pc_cur) + AW'(1))));

    // R2
    seq_pc_chk: assert property (@(posedge clk) disable iff (rst)
        br_valid |=> (push_req || (pc_next == $past(pc_cur) + AW'(1))));

    // R9
    flag_pair_chk: assert property (@(posedge clk) disable iff (rst)
        siop_set == uncc_set);

    // R9
    flag_needs_nan_chk: assert property (@(posedge clk) disable iff (rst)
        siop_set |-> $past(fnan));

    // R10
    unused_code_chk: assert property (@(posedge clk) disable iff (rst)
        (br_valid && (cond_sel > SEL_W'(LAST_CODE))) |=> (!push_req && !siop_set));

    // R9
    aware_no_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (br_valid && (cond_sel <= SEL_W'(6))) |=> !siop_set);

endmodule

// File: tb/sim_fpbr_unit.sv
module sim_fpbr_unit;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          br_valid = 1'b0;
    logic [31:0]   pc_cur = '0;
    logic [4:0]    cond_sel = '0;
    logic [1:0]    disp_mode = '0;
    logic [14:0]   disp_short = '0;
    logic [31:0]   disp_long = '0;
    logic [31:0]   reg_val = '0;
    logic [15:0]   sr_cur = '0;
    logic [9:0]    fl = '0;
    logic [31:0]   pc_next;
    logic          push_req;
    logic [31:0]   push_ret;
    logic [15:0]   push_sr;
    logic          siop_set;
    logic          uncc_set;

    // flag bit positions in fl: z n i nan uncc snan operr ovf unf dz
    localparam logic [9:0] FZ = 10'b1000000000;
    localparam logic [9:0] FN = 10'b0100000000;
    localparam logic [9:0] FI = 10'b0010000000;
    localparam logic [9:0] FNAN = 10'b0001000000;
    localparam logic [9:0] FUNCC = 10'b0000100000;
    localparam logic [9:0] FSNAN = 10'b0000010000;
    localparam logic [9:0] FOVF = 10'b0000000100;
    localparam logic [9:0] FDZ = 10'b0000000001;

    always #2.5 clk = ~clk;

    fpbr_unit u0 (
        .clk(clk), .rst(rst), .br_valid(br_valid), .pc_cur(pc_cur),
        .cond_sel(cond_sel), .disp_mode(disp_mode), .disp_short(disp_short),
        .disp_long(disp_long), .reg_val(reg_val), .sr_cur(sr_cur),
        .fz(fl[9]), .fn(fl[8]), .finf(fl[7]), .fnan(fl[6]), .funcc(fl[5]),
        .fsnan(fl[4]), .foperr(fl[3]), .fovf(fl[2]), .funf(fl[1]), .fdz(fl[0]),
        .pc_next(pc_next), .push_req(push_req), .push_ret(push_ret),
        .push_sr(push_sr), .siop_set(siop_set), .uncc_set(uncc_set)
    );

    typedef struct {
        string       tag;
        logic [31:0] pc;
        logic        push;
        logic [31:0] ret;
        logic [15:0] sr;
        logic        flg;
    } exp_t;

    exp_t        q[$];
    int          checks = 0;
    int          errors = 0;
    logic [31:0] model_pc = '0;
    bit          done = 0;

    // Bench-side condition model written from the requirement equations
    function automatic void ref_cond(input logic [4:0] c, input logic [9:0] f,
                                     output logic hit, output logic nonaw);
        logic z, n, i, nan, err;
        z = f[9]; n = f[8]; i = f[7]; nan = f[6]; err = |f[5:0];
        nonaw = (c >= 5'd7) && (c <= 5'd20);
        case (c)
            5'd0:  hit = z;
            5'd1:  hit = !z;
            5'd2:  hit = n;
            5'd3:  hit = !n;
            5'd4:  hit = !nan;
            5'd5:  hit = nan;
            5'd6:  hit = err;
            5'd7:  hit = !nan;
            5'd8:  hit = nan;
            5'd9:  hit = !(nan || (n && !z));
            5'd10: hit = (nan || (n && !z));
            5'd11: hit = !(nan || z);
            5'd12: hit = (nan || z);
            5'd13: hit = !(nan || z || n);
            5'd14: hit = (nan || z || n);
            5'd15: hit = !(nan || !(n || z));
            5'd16: hit = (nan || !(n || z));
            5'd17: hit = !(nan || z || !n);
            5'd18: hit = (nan || z || !n);
            5'd19: hit = i;
            5'd20: hit = !i;
            default: hit = 1'b0;
        endcase
    endfunction

    task automatic br(input string tag, input logic [31:0] pc, input logic [4:0] c,
                      input logic [1:0] m, input logic [14:0] ds, input logic [31:0] dl,
                      input logic [31:0] rv, input logic [15:0] sr, input logic [9:0] f);
        exp_t  e;
        logic  hit, nonaw;
        logic [31:0] d;
        @(negedge clk);
        br_valid = 1'b1; pc_cur = pc; cond_sel = c; disp_mode = m;
        disp_short = ds; disp_long = dl; reg_val = rv; sr_cur = sr; fl = f;
        ref_cond(c, f, hit, nonaw);
        if (m == 2'd0) d = {{17{ds[14]}}, ds};
        else if (m == 2'd1) d = dl;
        else d = rv;
        e.tag  = tag;
        e.push = hit;
        e.ret  = pc + 32'd1;
        e.sr   = sr;
        e.pc   = hit ? (pc + 32'd1 + d) : (pc + 32'd1);
        e.flg  = nonaw && f[6];
        model_pc = e.pc;
        q.push_back(e);
    endtask

    task automatic idle(input string tag);
        exp_t e;
        @(negedge clk);
        br_valid = 1'b0;
        pc_cur = 32'hDEAD_BEEF; cond_sel = 5'd1; fl = FNAN;
        e.tag = tag; e.pc = model_pc; e.push = 1'b0; e.ret = '0; e.sr = '0; e.flg = 1'b0;
        q.push_back(e);
    endtask

    // Monitor: compares each issued item one edge later, away from the edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (pc_next !== e.pc || push_req !== e.push || siop_set !== e.flg ||
                    uncc_set !== e.flg ||
                    (e.push && (push_ret !== e.ret || push_sr !== e.sr))) begin
                    errors++;
                    $display("FAIL %s: pc=%h push=%b ret=%h sr=%h siop=%b uncc=%b expected pc=%h push=%b ret=%h sr=%h flags=%b",
                             e.tag, pc_next, push_req, push_ret, push_sr, siop_set, uncc_set,
                             e.pc, e.push, e.ret, e.sr, e.flg);
                end
            end
        end
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: timeout reached, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (pc_next !== 32'd0 || push_req !== 1'b0 || siop_set !== 1'b0 || uncc_set !== 1'b0) begin
            errors++;
            $display("FAIL R1: pc=%h push=%b siop=%b uncc=%b expected 0 0 0 0",
                     pc_next, push_req, siop_set, uncc_set);
        end
        @(negedge clk);
        rst = 1'b0;

        // R6 simple conditions
        br("R6 EQ taken",   32'h100, 5'd0,  2'd0, 15'd8, 0, 0, 16'h1234, FZ);
        br("R6 EQ not",     32'h200, 5'd0,  2'd0, 15'd8, 0, 0, 16'h1234, 10'd0);
        br("R6 NE",         32'h300, 5'd1,  2'd0, 15'd4, 0, 0, 16'h0001, 10'd0);
        br("R6 MI",         32'h310, 5'd2,  2'd0, 15'd4, 0, 0, 16'h0002, FN);
        br("R6 PL",         32'h320, 5'd3,  2'd0, 15'd4, 0, 0, 16'h0003, FN);
        br("R6 OR",         32'h330, 5'd4,  2'd0, 15'd4, 0, 0, 16'h0004, 10'd0);
        br("R6 UN",         32'h340, 5'd5,  2'd0, 15'd4, 0, 0, 16'h0005, FNAN);
        br("R6 GLE",        32'h350, 5'd7,  2'd0, 15'd4, 0, 0, 16'h0006, 10'd0);
        br("R6 INF",        32'h360, 5'd19, 2'd0, 15'd4, 0, 0, 16'h0007, FI);
        br("R6 NINF",       32'h370, 5'd20, 2'd0, 15'd4, 0, 0, 16'h0008, FI);
        // R7 ordered comparisons
        br("R7 GE pos",     32'h400, 5'd9,  2'd0, 15'd16, 0, 0, 16'h0010, 10'd0);
        br("R7 GE neg",     32'h410, 5'd9,  2'd0, 15'd16, 0, 0, 16'h0011, FN);
        br("R7 NGE neg",    32'h420, 5'd10, 2'd0, 15'd16, 0, 0, 16'h0012, FN);
        br("R7 GL zero",    32'h430, 5'd11, 2'd0, 15'd16, 0, 0, 16'h0013, FZ);
        br("R7 NGL zero",   32'h440, 5'd12, 2'd0, 15'd16, 0, 0, 16'h0014, FZ);
        br("R7 GT pos",     32'h450, 5'd13, 2'd0, 15'd16, 0, 0, 16'h0015, 10'd0);
        br("R7 NGT zero",   32'h460, 5'd14, 2'd0, 15'd16, 0, 0, 16'h0016, FZ);
        br("R7 LE zero",    32'h470, 5'd15, 2'd0, 15'd16, 0, 0, 16'h0017, FZ);
        br("R7 NLE pos",    32'h480, 5'd16, 2'd0, 15'd16, 0, 0, 16'h0018, 10'd0);
        br("R7 LT neg",     32'h490, 5'd17, 2'd0, 15'd16, 0, 0, 16'h0019, FN);
        br("R7 NLT neg",    32'h4A0, 5'd18, 2'd0, 15'd16, 0, 0, 16'h001A, FN);
        br("R7 LT negzero", 32'h4B0, 5'd17, 2'd0, 15'd16, 0, 0, 16'h001B, FN | FZ);
        // R8 error condition
        br("R8 ERR dz",     32'h500, 5'd6,  2'd0, 15'd2, 0, 0, 16'h0020, FDZ);
        br("R8 ERR none",   32'h510, 5'd6,  2'd0, 15'd2, 0, 0, 16'h0021, FZ | FN | FI | FNAN);
        br("R8 ERR ovf",    32'h520, 5'd6,  2'd0, 15'd2, 0, 0, 16'h0022, FOVF | FSNAN);
        br("R8 ERR uncc",   32'h530, 5'd6,  2'd0, 15'd2, 0, 0, 16'h0023, FUNCC);
        // R9 non-aware under NaN, including taken together with the pulse
        br("R9 GE nan",     32'h600, 5'd9,  2'd0, 15'd3, 0, 0, 16'h0030, FNAN);
        br("R9 NGE nan",    32'h610, 5'd10, 2'd1, 0, 32'h40, 0, 16'h0031, FNAN);
        br("R9 NGT nan",    32'h620, 5'd14, 2'd0, 15'd9, 0, 0, 16'h0032, FNAN | FN);
        br("R9 INF nan",    32'h630, 5'd19, 2'd0, 15'd9, 0, 0, 16'h0033, FNAN | FI);
        br("R9 EQ nan",     32'h640, 5'd0,  2'd0, 15'd9, 0, 0, 16'h0034, FNAN | FZ);
        br("R9 UN nan",     32'h650, 5'd5,  2'd0, 15'd9, 0, 0, 16'h0035, FNAN);
        // R10 unused codes
        br("R10 code21",    32'h700, 5'd21, 2'd0, 15'd9, 0, 0, 16'h0040, FNAN | FZ);
        br("R10 code31",    32'h710, 5'd31, 2'd1, 0, 32'h9, 0, 16'h0041, 10'h3FF);
        // R4 short sign extension
        br("R4 short -1",   32'h800, 5'd1,  2'd0, 15'h7FFF, 0, 0, 16'h0050, 10'd0);
        br("R4 short min",  32'h8000, 5'd1, 2'd0, 15'h4000, 0, 0, 16'h0051, 10'd0);
        br("R4 short max",  32'h900, 5'd1,  2'd0, 15'h3FFF, 0, 0, 16'h0052, 10'd0);
        // R5 long and register forms
        br("R5 long",       32'hA00, 5'd1,  2'd1, 15'h7FFF, 32'h0001_0000, 32'h55, 16'h0060, 10'd0);
        br("R5 reg2",       32'hB00, 5'd1,  2'd2, 15'h7FFF, 32'h77, 32'hFFFF_FF00, 16'h0061, 10'd0);
        br("R5 reg3",       32'hC00, 5'd1,  2'd3, 15'h1, 32'h77, 32'h0000_0500, 16'h0062, 10'd0);
        // R12 wrap-around
        br("R12 seq wrap",  32'hFFFF_FFFF, 5'd0, 2'd0, 15'd5, 0, 0, 16'h0070, 10'd0);
        br("R12 tgt wrap",  32'hFFFF_FFF0, 5'd1, 2'd1, 0, 32'h20, 0, 16'h0071, 10'd0);
        br("R12 neg wrap",  32'h0000_0002, 5'd1, 2'd0, 15'h7FF0, 0, 0, 16'h0072, 10'd0);
        // R11 idle cycles hold state
        idle("R11 idle a");
        idle("R11 idle b");
        br("R3 after idle", 32'h1234, 5'd1, 2'd0, 15'd7, 0, 0, 16'hBEEF, 10'd0);
        br("R2 back2back",  32'h5678, 5'd0, 2'd0, 15'd7, 0, 0, 16'hCAFE, 10'd0);
        idle("R11 idle c");

        @(negedge clk);
        br_valid = 1'b0;
        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule